// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog for a chip-level peripheral bus. Software writes a tick count into the timer register, and each later write to that register is a keepalive that reloads the count. A write to the timer register passes through a fixed synchronisation delay of `LOAD_LAT` clock edges before the new count reaches the counter. While the action field of the control register is non-zero, the counter steps down by one every clock. When it reaches zero the block carries out the selected action once: a general-purpose interrupt, a non-maskable interrupt, or a one-cycle request for a full-chip reset. Action 0 leaves the watchdog switched off.

The core is a three-state machine. `S_IDLE` means the watchdog is off and the count holds. `S_RUN` means the count is decrementing. `S_EXPIRED` means the action has fired and the count holds at zero. The transitions are:

- *enable* (`S_IDLE` to `S_RUN`): a control write with a non-zero action.
- *expire* (`S_RUN` to `S_EXPIRED`): the count is zero with no reload landing and no disable write.
- *reload* (any state to `S_RUN` when the action is non-zero, or to `S_IDLE` when it is zero): a timer value lands.
- *disable* (any state to `S_IDLE`): a control write with action 0.

A sticky reset-cause flag records that the chip reset was caused by the watchdog. The flag is cleared only by the power-on reset input. The ordinary reset input returns every other piece of state to zero.

Top module: `watchdog_action_timer`

## Requirements
- R1: After power-on reset, both registers read 0 and `irq_gp`, `irq_nmi` and `rst_req` are low.
- R2: Byte offset 0x0 is the control register. Bits [1:0] hold the action (0 none, 1 general interrupt, 2 non-maskable interrupt, 3 chip reset) and bit 31 is the read-only reset-cause flag. All other bits read 0. Byte offset 0x4 is the timer register and reads the live count. Any other offset reads 0, and writes to it change nothing.
- R3: A value written to offset 0x4 appears in the count exactly `LOAD_LAT` rising edges after the edge that captured the write (default 3).
- R4: In `S_RUN` with a non-zero count, the count falls by exactly one per clock. A control write that enables the watchdog does not decrement on its own edge.
- R5: From a count of N that lands while the action is non-zero, the action fires N+1 edges after the landing edge. The count then holds at zero and the action does not fire again until a reload lands.
- R6: Action 1 drives `irq_gp` and action 2 drives `irq_nmi`. Each is a level that stays high until a reload lands or action 0 is written. At most one of the three action outputs is high at a time.
- R7: Action 3 makes `rst_req` high for exactly one cycle. On that same edge the reset-cause flag is set.
- R8: The reset-cause flag survives `rst_n`, which clears the action and the count. Only `por_n` clears the flag.
- R9: Writing action 0 moves the block to `S_IDLE` and clears both interrupts on the next edge. The count then holds and expiry has no effect.
- R10: When a reload lands, or action 0 is written, in the very cycle that would fire the action, the action does not fire.
- R11: Back-to-back timer writes land in order, one per edge, each after the same delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the flag |
| rst_n | input | 1 | Chip reset, active low; clears all but the reset-cause flag |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq_gp | output | 1 | General-purpose interrupt level |
| irq_nmi | output | 1 | Non-maskable interrupt level |
| rst_req | output | 1 | One-cycle full-chip reset request |

## Verification
Expiry can fall in the same cycle as the landing of a keepalive, or in the same cycle as a disable write. In both cases the reload or the disable must win. The bench times a second timer write exactly `LOAD_LAT` edges before the count would reach its firing cycle. It then times an action-0 write onto the next firing cycle. It judges both by requiring the interrupt output to stay low and the count to read the reloaded value or zero. A behavioural reference model with a queue of pending loads runs in parallel, and every clock the outputs and read data are compared against it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RUN     = 2'd1,
        S_EXPIRED = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_RESET = 2'd3
    } wdt_act_e;

    localparam int CTRL_OFFSET  = 0;
    localparam int TIMER_OFFSET = 4;

endpackage

// File: rtl/wdt_load_sync.sv
module wdt_load_sync #(
    parameter int DATA_W   = 32,
    parameter int LOAD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_data,
    output logic              land,
    output logic [DATA_W-1:0] land_data
);

    localparam int LAST = LOAD_LAT - 1;

    for (genvar i = 0; i < LOAD_LAT; i++) begin : g_stage
        logic              v;
        logic [DATA_W-1:0] d;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= load_wr;
                    d <= load_data;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= g_stage[i-1].v;
                    d <= g_stage[i-1].d;
                end
            end
            // R11: each stage hands its entry to the next on the following edge
            p_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
                g_stage[i-1].v |=> (v && d == $past(g_stage[i-1].d)));
        end
    end

    assign land      = g_stage[LAST].v;
    assign land_data = g_stage[LAST].d;

    // R3: a timer write is captured at the edge that samples it
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (g_stage[0].v && g_stage[0].d == $past(load_data)));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              fire_reset,
    output wdt_act_e          act,
    output wdt_act_e          new_act,
    output logic              ctrl_wr,
    output logic              timer_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] A_TIMER = ADDR_W'(TIMER_OFFSET);
    localparam int                FLAG_B  = DATA_W - 1;

    logic cause_flag;

    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign timer_wr = bus_wr && (bus_addr == A_TIMER);
    assign new_act  = wdt_act_e'(bus_wdata[1:0]);

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            act <= ACT_NONE;
        end else if (ctrl_wr) begin
            act <= new_act;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_flag <= 1'b0;
        end else if (fire_reset) begin
            cause_flag <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[FLAG_B] = cause_flag;
            bus_rdata[1:0]    = act;
        end else if (bus_addr == A_TIMER) begin
            bus_rdata = cnt;
        end
    end

    // R8: once set, the reset-cause flag survives until power-on reset
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
        cause_flag |=> cause_flag);

    // R2: software cannot set the flag through a control write
    p_flag_ro_r2: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_wr && !fire_reset && !cause_flag) |=> !cause_flag);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wdt_act_e          act,
    input  logic              ctrl_wr,
    input  wdt_act_e          new_act,
    input  logic              land,
    input  logic [DATA_W-1:0] land_data,
    output logic [DATA_W-1:0] cnt,
    output logic              fire_reset,
    output logic              irq_gp,
    output logic              irq_nmi,
    output logic              rst_req
);

    wdt_state_e state, nstate;
    wdt_act_e   eff_act;
    logic       disable_now;
    logic       fire;

    assign eff_act     = ctrl_wr ? new_act : act;
    assign disable_now = ctrl_wr && (new_act == ACT_NONE);
    assign fire        = (state == S_RUN) && (cnt == '0) && !land && !disable_now;
    assign fire_reset  = fire && (act == ACT_RESET);

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (disable_now)                       nstate = S_IDLE;
                else if (land)                         nstate = (eff_act != ACT_NONE) ? S_RUN : S_IDLE;
                else if (ctrl_wr)                      nstate = S_RUN;
            end
            S_RUN: begin
                if (disable_now)                       nstate = S_IDLE;
                else if (land)                         nstate = S_RUN;
                else if (fire)                         nstate = S_EXPIRED;
            end
            S_EXPIRED: begin
                if (disable_now)                       nstate = S_IDLE;
                else if (land)                         nstate = S_RUN;
            end
            default:                                   nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (land) begin
            cnt <= land_data;
        end else if (state == S_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_gp  <= 1'b0;
            irq_nmi <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire_reset;
            if (land || disable_now) begin
                irq_gp  <= 1'b0;
                irq_nmi <= 1'b0;
            end else if (fire) begin
                if (act == ACT_IRQ) irq_gp  <= 1'b1;
                if (act == ACT_NMI) irq_nmi <= 1'b1;
            end
        end
    end

    // R7: the reset request lasts exactly one cycle
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: at most one action output at a time
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_gp, irq_nmi, rst_req}));

    // R4: one step down per clock while running
    p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && cnt != '0 && !land) |=> (cnt == $past(cnt) - 1'b1));

    // R9: the count holds while switched off
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !land) |=> $stable(cnt));

    // R5: after firing, the count stays at zero and no second reset pulse follows
    p_expired_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXPIRED && !land) |=> (cnt == '0 && !rst_req));

    // R10: a landing reload leaves every action output low on the next cycle
    p_land_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        land |=> (!rst_req && !irq_gp && !irq_nmi));

endmodule

// File: rtl/watchdog_action_timer.sv
module watchdog_action_timer
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int LOAD_LAT = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_gp,
    output logic              irq_nmi,
    output logic              rst_req
);

    logic              sys_rst_n;
    wdt_act_e          act;
    wdt_act_e          new_act;
    logic              ctrl_wr;
    logic              timer_wr;
    logic              land;
    logic [DATA_W-1:0] land_data;
    logic [DATA_W-1:0] cnt;
    logic              fire_reset;

    assign sys_rst_n = por_n & rst_n;

    wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .por_n      (por_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt        (cnt),
        .fire_reset (fire_reset),
        .act        (act),
        .new_act    (new_act),
        .ctrl_wr    (ctrl_wr),
        .timer_wr   (timer_wr),
        .bus_rdata  (bus_rdata)
    );

    wdt_load_sync #(.DATA_W(DATA_W), .LOAD_LAT(LOAD_LAT)) u_sync (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .load_wr   (timer_wr),
        .load_data (bus_wdata),
        .land      (land),
        .land_data (land_data)
    );

    wdt_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .act        (act),
        .ctrl_wr    (ctrl_wr),
        .new_act    (new_act),
        .land       (land),
        .land_data  (land_data),
        .cnt        (cnt),
        .fire_reset (fire_reset),
        .irq_gp     (irq_gp),
        .irq_nmi    (irq_nmi),
        .rst_req    (rst_req)
    );

endmodule

// File: tb/sim_watchdog_action_timer.sv
`timescale 1ns/1ps
module sim_watchdog_action_timer;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_gp, irq_nmi, rst_req;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    watchdog_action_timer #(.ADDR_W(4), .DATA_W(32), .LOAD_LAT(LAT)) u0 (
        .clk, .por_n, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
        .bus_rdata, .irq_gp, .irq_nmi, .rst_req
    );

    // behavioural reference model
    int          m_state = 0;
    logic [31:0] m_cnt = 0;
    logic [1:0]  m_act = 0;
    bit          m_flag = 0, m_gp = 0, m_nmi = 0, m_rst = 0;
    logic [31:0] q_val[$];
    int          q_rem[$];

    always @(posedge clk) begin
        if (!por_n || !rst_n) begin
            if (!por_n) m_flag = 0;
            m_state = 0; m_cnt = 0; m_act = 0;
            m_gp = 0; m_nmi = 0; m_rst = 0;
            q_val.delete(); q_rem.delete();
        end else begin
            bit          land, cw, dis, fire;
            logic [31:0] lval;
            logic [1:0]  nact;
            int          ns;
            land = 0; lval = 0;
            foreach (q_rem[i]) q_rem[i] = q_rem[i] - 1;
            if (q_rem.size() > 0 && q_rem[0] == 0) begin
                land = 1; lval = q_val[0];
                void'(q_val.pop_front()); void'(q_rem.pop_front());
            end
            cw   = bus_wr && bus_addr == 4'h0;
            nact = cw ? bus_wdata[1:0] : m_act;
            dis  = cw && bus_wdata[1:0] == 2'd0;
            fire = m_state == 1 && m_cnt == 0 && !land && !dis;
            ns = m_state;
            if (dis) ns = 0;
            else if (land) ns = (nact != 0) ? 1 : 0;
            else if (fire) ns = 2;
            else if (m_state == 0 && cw) ns = 1;
            m_rst = fire && m_act == 2'd3;
            if (m_rst) m_flag = 1;
            if (land || dis) begin m_gp = 0; m_nmi = 0; end
            else if (fire) begin
                if (m_act == 2'd1) m_gp = 1;
                if (m_act == 2'd2) m_nmi = 1;
            end
            if (land) m_cnt = lval;
            else if (m_state == 1 && m_cnt != 0) m_cnt = m_cnt - 1;
            m_act = nact;
            m_state = ns;
            if (bus_wr && bus_addr == 4'h4) begin
                q_val.push_back(bus_wdata); q_rem.push_back(LAT);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        if (a == 4'h0) return {m_flag, 29'd0, m_act};
        if (a == 4'h4) return m_cnt;
        return 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (por_n && rst_n && !done) begin
            chk("R6 irq_gp", {31'd0, irq_gp}, {31'd0, m_gp});
            chk("R6 irq_nmi", {31'd0, irq_nmi}, {31'd0, m_nmi});
            chk("R7 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
            chk("R2 read data", bus_rdata, m_read(bus_addr));
        end
    end

    logic        s_gp, s_nmi, s_rst;
    logic [31:0] v;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [3:0] a, output logic [31:0] r);
        bus_addr = a;
        @(negedge clk);
        r = bus_rdata; s_gp = irq_gp; s_nmi = irq_nmi; s_rst = rst_req;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        #1; por_n = 1'b1; rst_n = 1'b1;

        // R1: reset state
        look(4'h0, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 outputs", {29'd0, s_gp, s_nmi, s_rst}, 32'h0);
        look(4'h4, v); chk("R1 timer", v, 32'h0);

        // R2: undefined offset ignored, flag read-only
        wr(4'h8, 32'hFFFF_FFFF);
        look(4'h8, v); chk("R2 undefined read", v, 32'h0);
        look(4'h0, v); chk("R2 ctrl untouched", v, 32'h0);
        wr(4'h0, 32'h8000_0000);
        look(4'h0, v); chk("R2 flag read-only", v, 32'h0);
        look(4'h4, v); chk("R2 timer untouched", v, 32'h0);

        // R3: load latency
        wr(4'h4, 32'd100);
        for (int i = 0; i < LAT; i++) begin
            look(4'h4, v); chk("R3 before landing", v, 32'h0);
        end
        look(4'h4, v); chk("R3 landed", v, 32'd100);
        look(4'h4, v); chk("R9 idle holds", v, 32'd100);

        // R4: decrement after enabling interrupt action
        wr(4'h0, 32'd1);
        look(4'h4, v); chk("R4 enable edge", v, 32'd100);
        look(4'h4, v); chk("R4 step1", v, 32'd99);
        look(4'h4, v); chk("R4 step2", v, 32'd98);

        // R5: expiry timing from reload of 5
        wr(4'h4, 32'd5);
        k = 0; s_gp = 0;
        while (k < 40) begin
            look(4'h0, v);
            if (s_gp) break;
            k++;
        end
        chk("R5 fire cycle", k, LAT + 5 + 1);
        look(4'h4, v); chk("R5 holds zero", v, 32'h0);
        chk("R6 gp level", {31'd0, s_gp}, 32'd1);

        // R6: reload clears the interrupt when it lands
        wr(4'h4, 32'd3);
        for (int i = 0; i < LAT; i++) begin
            look(4'h4, v); chk("R6 gp until landing", {31'd0, s_gp}, 32'd1);
        end
        look(4'h4, v); chk("R6 gp cleared", {31'd0, s_gp}, 32'd0);
        chk("R6 reload value", v, 32'd3);
        look(4'h4, v); look(4'h4, v); look(4'h4, v);
        look(4'h4, v); chk("R5 refire after reload", {31'd0, s_gp}, 32'd1);

        // R9: disable clears interrupt
        wr(4'h0, 32'd0);
        look(4'h0, v); chk("R9 ctrl off", v, 32'h0);
        chk("R9 gp cleared", {31'd0, s_gp}, 32'd0);

        // R6: NMI action
        wr(4'h4, 32'd4);
        repeat (LAT) step();
        wr(4'h0, 32'd2);
        k = 0; s_nmi = 0;
        while (k < 40) begin
            look(4'h4, v);
            if (s_nmi) break;
            k++;
        end
        chk("R6 nmi fire cycle", k, 5);
        chk("R6 gp stays low", {31'd0, s_gp}, 32'd0);

        // R10: keepalive landing in the firing cycle
        wr(4'h4, 32'd10);
        repeat (10) step();
        wr(4'h4, 32'd10);
        for (int i = 0; i < LAT; i++) begin
            look(4'h4, v); chk("R10 no nmi", {31'd0, s_nmi}, 32'd0);
        end
        look(4'h4, v); chk("R10 reload won", v, 32'd10);
        chk("R10 no nmi at landing", {31'd0, s_nmi}, 32'd0);
        repeat (9) step();
        wr(4'h0, 32'd0);
        look(4'h4, v); chk("R10 disable won", {31'd0, s_nmi}, 32'd0);
        chk("R10 count zero", v, 32'h0);
        look(4'h4, v); chk("R10 still no nmi", {31'd0, s_nmi}, 32'd0);

        // R7: reset action
        wr(4'h4, 32'd2);
        repeat (LAT) step();
        wr(4'h0, 32'd3);
        k = 0; s_rst = 0;
        while (k < 40) begin
            look(4'h0, v);
            if (s_rst) break;
            k++;
        end
        chk("R7 reset fire cycle", k, 3);
        chk("R7 flag set", v, 32'h8000_0003);
        look(4'h0, v); chk("R7 single pulse", {31'd0, s_rst}, 32'd0);

        // R8: flag survives chip reset
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        look(4'h0, v); chk("R8 flag survives", v, 32'h8000_0000);
        look(4'h4, v); chk("R8 count cleared", v, 32'h0);
        por_n = 1'b0; step(); por_n = 1'b1;
        look(4'h0, v); chk("R8 por clears flag", v, 32'h0);

        // R11: back-to-back writes
        wr(4'h4, 32'd7);
        wr(4'h4, 32'd9);
        look(4'h4, v); chk("R11 k0", v, 32'h0);
        look(4'h4, v); chk("R11 k1", v, 32'h0);
        look(4'h4, v); chk("R11 first", v, 32'd7);
        look(4'h4, v); chk("R11 second", v, 32'd9);

        finish_run();
    end

endmodule